// File: doc/BRIEF.md
# Eight-Key Command Keypad Encoder

This block sits between a row of eight pushbuttons and a parallel input port. Each button pulls its line low while it is held and leaves it high otherwise. The block synchronises the eight lines to the system clock and picks a single key number by priority, so that the highest-numbered key held wins. It accepts that number only after it has stayed unchanged for a set debounce interval. It then presents an ASCII digit from '0' to '7' on an eight-bit output, followed by a strobe pulse of fixed width.

A controller (IDLE, SETUP, PULSE, HOLD) gives one strobe per press. IDLE waits for an accepted key. The transition IDLE->SETUP latches the key number into the output byte. SETUP->PULSE always follows one cycle later and raises the strobe. PULSE->HOLD happens after the programmed number of strobe cycles. HOLD->IDLE happens only once the debounced input shows no key at all. The byte keeps its value until the next accepted press.

Top module: `keypad_cmd_encoder`

## Requirements
- R1: During and after reset, `cmd_strobe` is low and `cmd_byte` is 0x30 until a key is accepted.
- R2: Bit i of `key_n` is key i, and 0 means pressed. When several keys are held, the key number is the highest index among them, and it appears on `cmd_byte[2:0]`.
- R3: `cmd_byte` is always 0x30 plus the key number: bits 7, 6 and 3 are 0, and bits 5 and 4 are 1.
- R4: A key pattern must be seen unchanged at the synchronizer output for DEBOUNCE_CYCLES+1 consecutive cycles before it is accepted. Shorter patterns, chatter and idle lines give no strobe. When a pattern is applied before a clock edge and then held, the strobe is first high in the cycle after edge DEBOUNCE_CYCLES+SYNC_STAGES+3.
- R5: Each strobe is high for exactly STROBE_CYCLES consecutive cycles.
- R6: One press gives exactly one strobe. Adding keys, or changing keys, while at least one key stays held gives no further strobe.
- R7: A new strobe becomes possible only after the debounced input has shown no key pressed. A release shorter than the debounce window does not re-arm the block.
- R8: `cmd_byte` holds its value from the cycle before the strobe rises until after it falls, and stays unchanged until the next accepted press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_n | input | 8 | Raw pushbutton lines, low while pressed |
| cmd_byte | output | 8 | ASCII digit of the accepted key |
| cmd_strobe | output | 1 | Pulse announcing a new command byte |

## Verification
The bench builds the block with DEBOUNCE_CYCLES=4, STROBE_CYCLES=3 and two synchronizer stages. These values are short enough to press every one of the 255 non-empty key combinations in turn, and each press checks the chosen digit, the exact strobe latency and width, and byte stability. The small debounce window also puts glitches of exactly the rejected length, chatter, partial releases and brief full releases within reach. Each of these cases is checked against the one-strobe-per-press rule.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int KEY_COUNT = 8;
    localparam int CODE_W    = $clog2(KEY_COUNT);
    localparam logic [7:0] CMD_BASE = 8'h30;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_PULSE = 2'd2,
        ST_HOLD  = 2'd3
    } kp_state_e;

    typedef struct packed {
        logic              pressed;
        logic [CODE_W-1:0] code;
    } kp_key_t;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= '1;
                else        chain[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '1;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/kp_prio_enc.sv
module kp_prio_enc
    import kp_pkg::*;
(
    input  logic [KEY_COUNT-1:0] lines_n,
    output kp_key_t              key
);
    always_comb begin
        key = '0;
        for (int i = 0; i < KEY_COUNT; i++) begin
            if (!lines_n[i]) begin
                key.pressed = 1'b1;
                key.code    = CODE_W'(i);
            end
        end
    end
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce
    import kp_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  kp_key_t raw,
    output kp_key_t stable
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(DEBOUNCE_CYCLES);

    kp_key_t          cand;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand   <= '0;
            cnt    <= '0;
            stable <= '0;
        end else if (raw != cand) begin
            cand <= raw;
            cnt  <= '0;
        end else begin
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            if (cnt == CNT_LAST) stable <= cand;
        end
    end
endmodule

// File: rtl/kp_strobe_fsm.sv
module kp_strobe_fsm
    import kp_pkg::*;
#(
    parameter int STROBE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  kp_key_t           accepted,
    output logic [CODE_W-1:0] code_q,
    output logic              strobe
);
    localparam int PW = $clog2(STROBE_CYCLES + 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(STROBE_CYCLES - 1);

    kp_state_e     state, state_n;
    logic [PW-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (accepted.pressed)   state_n = ST_SETUP;
            ST_SETUP:                         state_n = ST_PULSE;
            ST_PULSE: if (pcnt == PULSE_LAST) state_n = ST_HOLD;
            ST_HOLD:  if (!accepted.pressed)  state_n = ST_IDLE;
            default:                          state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            strobe <= 1'b0;
            pcnt   <= '0;
        end else begin
            if (state == ST_IDLE && accepted.pressed) code_q <= accepted.code;
            strobe <= (state_n == ST_PULSE);
            if (state == ST_PULSE) pcnt <= pcnt + 1'b1;
            else                   pcnt <= '0;
        end
    end
endmodule

// File: rtl/keypad_cmd_encoder.sv
module keypad_cmd_encoder
    import kp_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 20000,
    parameter int STROBE_CYCLES   = 64,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] key_n,
    output logic [7:0] cmd_byte,
    output logic       cmd_strobe
);
    logic [KEY_COUNT-1:0] lines_s;
    kp_key_t              raw_key;
    kp_key_t              deb_key;
    logic [CODE_W-1:0]    code_q;
    logic                 deb_valid;
    logic [CODE_W-1:0]    deb_code;

    kp_sync #(.WIDTH(KEY_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(key_n), .dout(lines_s)
    );

    kp_prio_enc u_enc (.lines_n(lines_s), .key(raw_key));

    kp_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk(clk), .rst_n(rst_n), .raw(raw_key), .stable(deb_key)
    );

    kp_strobe_fsm #(.STROBE_CYCLES(STROBE_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .accepted(deb_key),
        .code_q(code_q), .strobe(cmd_strobe)
    );

    assign deb_valid = deb_key.pressed;
    assign deb_code  = deb_key.code;
    assign cmd_byte  = CMD_BASE | {{(8-CODE_W){1'b0}}, code_q};
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
    parameter int STROBE_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cmd_byte,
    input logic       cmd_strobe,
    input logic       deb_valid,
    input logic [2:0] deb_code
);
    localparam int RW = $clog2(STROBE_CYCLES + 2);
    localparam logic [RW-1:0] RUN_MAX = RW'(STROBE_CYCLES);

    logic [RW-1:0] run;
    logic          fired;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run   <= '0;
            fired <= 1'b0;
        end else begin
            run <= cmd_strobe ? run + 1'b1 : '0;
            if (cmd_strobe)      fired <= 1'b1;
            else if (!deb_valid) fired <= 1'b0;
        end
    end

    p_strobe_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> run < RUN_MAX);
    p_strobe_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_strobe) |-> run == RUN_MAX);
    p_byte_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> $stable(cmd_byte));
    p_byte_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_strobe) |-> $stable(cmd_byte));
    // also covers R7: re-arming only after a debounced full release
    p_single_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_strobe) |-> !fired);
    p_code_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_strobe) |-> ($past(deb_valid, 2) && cmd_byte[2:0] == $past(deb_code, 2)));
endmodule

bind keypad_cmd_encoder kp_checker #(.STROBE_CYCLES(STROBE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .cmd_strobe(cmd_strobe),
    .deb_valid(deb_valid), .deb_code(deb_code)
);

// File: tb/keypad_cmd_encoder_test.sv
module keypad_cmd_encoder_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DB  = 4;
    localparam int STB = 3;
    localparam int SYN = 2;
    localparam int LAT = DB + SYN + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] key_n = 8'hFF;
    logic [7:0] cmd_byte;
    logic       cmd_strobe;

    int total = 0, bad = 0;
    int rise_cnt = 0, last_w = 0, cur_w = 0, unstable = 0;
    logic       prev_s = 1'b0;
    logic [7:0] prev_byte = 8'h30;

    keypad_cmd_encoder #(.DEBOUNCE_CYCLES(DB), .STROBE_CYCLES(STB), .SYNC_STAGES(SYN)) uut (
        .clk(clk), .rst_n(rst_n), .key_n(key_n), .cmd_byte(cmd_byte), .cmd_strobe(cmd_strobe)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_strobe && !prev_s) begin
                rise_cnt++;
                cur_w = 1;
                if (cmd_byte != prev_byte) unstable++;
            end else if (cmd_strobe) begin
                cur_w++;
                if (cmd_byte != prev_byte) unstable++;
            end else if (prev_s) begin
                last_w = cur_w;
                if (cmd_byte != prev_byte) unstable++;
            end
        end
        prev_s    = cmd_strobe;
        prev_byte = cmd_byte;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int top_key(input logic [7:0] mask);
        int r = 0;
        for (int i = 0; i < 8; i++) if (mask[i]) r = i;
        return r;
    endfunction

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic press(input logic [7:0] mask);
        int base = rise_cnt;
        int u0 = unstable;
        int first = 0;
        int exp = top_key(mask);
        @(negedge clk);
        key_n = ~mask;
        for (int i = 1; i <= DB + STB + 12; i++) begin
            @(negedge clk);
            #1;
            if (first == 0 && cmd_strobe) first = i;
        end
        chk(first == LAT, "R4", "strobe latency", first, LAT);
        chk(rise_cnt - base == 1, "R6", "strobes per press", rise_cnt - base, 1);
        chk(int'(cmd_byte[2:0]) == exp, "R2", "key number", cmd_byte[2:0], exp);
        chk(cmd_byte == 8'h30 + 8'(exp), "R3", "ascii byte", cmd_byte, 8'h30 + exp);
        chk(last_w == STB, "R5", "strobe width", last_w, STB);
        chk(unstable == u0, "R8", "byte changes near strobe", unstable - u0, 0);
        @(negedge clk);
        key_n = 8'hFF;
        wait_cyc(DB + 10);
        chk(rise_cnt - base == 1, "R7", "strobe on release", rise_cnt - base, 1);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk(cmd_strobe == 1'b0, "R1", "strobe in reset", cmd_strobe, 0);
        chk(cmd_byte == 8'h30, "R1", "byte in reset", cmd_byte, 8'h30);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(40);
        chk(rise_cnt == 0, "R1", "strobe while idle", rise_cnt, 0);
        chk(cmd_byte == 8'h30, "R1", "byte after reset", cmd_byte, 8'h30);

        // R2 R3 R4 R5 R6 R8: every non-empty key combination
        for (int m = 1; m < 256; m++) press(8'(m));

        // R4: pattern held exactly DB cycles is rejected
        base = rise_cnt;
        @(negedge clk); key_n = ~8'h04;
        repeat (DB) @(negedge clk);
        key_n = 8'hFF;
        wait_cyc(30);
        chk(rise_cnt == base, "R4", "short glitch strobes", rise_cnt - base, 0);
        chk(cmd_byte == 8'h37, "R8", "byte kept after glitch", cmd_byte, 8'h37);

        // R4: chatter then steady press gives a single strobe
        base = rise_cnt;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); key_n = ~8'h20;
            @(negedge clk);
            @(negedge clk); key_n = 8'hFF;
            @(negedge clk);
        end
        @(negedge clk); key_n = ~8'h20;
        wait_cyc(DB + STB + 20);
        chk(rise_cnt - base == 1, "R4", "chatter strobes", rise_cnt - base, 1);
        chk(cmd_byte == 8'h35, "R2", "chatter key", cmd_byte, 8'h35);

        // R6: add a higher key while held
        @(negedge clk); key_n = ~8'hA0;
        wait_cyc(40);
        chk(rise_cnt - base == 1, "R6", "strobe on added key", rise_cnt - base, 1);
        chk(cmd_byte == 8'h35, "R8", "byte while held", cmd_byte, 8'h35);

        // R7: partial release, then brief full release
        @(negedge clk); key_n = ~8'h80;
        wait_cyc(40);
        chk(rise_cnt - base == 1, "R7", "strobe on partial release", rise_cnt - base, 1);
        @(negedge clk); key_n = 8'hFF;
        repeat (DB) @(negedge clk);
        key_n = ~8'h80;
        wait_cyc(40);
        chk(rise_cnt - base == 1, "R7", "strobe on brief release", rise_cnt - base, 1);
        @(negedge clk); key_n = 8'hFF;
        wait_cyc(DB + 10);
        chk(rise_cnt - base == 1, "R7", "strobe on full release", rise_cnt - base, 1);

        // R7: re-armed after full release
        press(8'h08);
        chk(rise_cnt - base == 2, "R7", "strobe after re-arm", rise_cnt - base, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule